// File: doc/BRIEF.md
# Shift Chain Error Event Monitor

This block watches the serial output of one register chain under test during a fault-injection or radiation run. It drives the chain input with a square wave that changes level on every clock. It keeps its own copy of that wave, delayed by the known chain latency, and compares the copy with the bit that comes back from the chain on every clock edge.

Consecutive mismatches form a run, and the block grades each run by its length. A run of one sample is a single upset. A run of two or more samples that ends before the interrupt threshold is one long upset. A run that reaches the threshold is a functional interrupt. Each grade has its own 16-bit counter that saturates. A one-cycle event pulse marks every counter update. A sticky interrupt flag tells the host that the device needs reprogramming. While that flag is set, grading stops until the host pulses the clear input.

A test fixture places one instance per chain. Nine chains need nine independent copies.

Top module: `chain_err_monitor`

## Requirements
- R1: After a synchronous reset, `stimOut` is 0, all three counters are 0, `irqFlag` is 0 and `evtPulse` is 0.
- R2: After reset, `stimOut` is 0 for the first clock edge and then inverts on every clock edge.
- R3: At the n-th edge after reset (n = 0 for the first edge), the expected chain bit is ((n + LATENCY) mod 2), which is the stimulus delayed by exactly LATENCY edges. When `chainIn` always carries that value, no counter changes. A chain that delivers the wave one edge late mismatches on every sample.
- R4: A run of exactly one mismatching sample adds 1 to `upsetCnt` on the first matching edge after it. `evtPulse` is high for exactly the cycle after that edge.
- R5: A run of 2 to SEFI_RUN-1 (49) consecutive mismatches adds exactly 1 to `longCnt` when the run ends, and leaves `upsetCnt` and `sefiCnt` unchanged.
- R6: On the edge that samples the SEFI_RUN-th (50th) consecutive mismatch, `sefiCnt` increments once and `irqFlag` sets. Both are visible after that edge.
- R7: While `irqFlag` is set, further mismatches and run ends change no counter.
- R8: A pulse on `clrIrq` clears `irqFlag` and the current run. A later single mismatch is counted again as an upset.
- R9: Each counter is 16 bits wide and stops at 65535 instead of wrapping.
- R10: A synchronous reset in the middle of operation clears the counters, the run length and `irqFlag`, and restarts the stimulus at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Check clock |
| rst | input | 1 | Synchronous active-high reset |
| clrIrq | input | 1 | Clears the sticky interrupt flag and the current run |
| chainIn | input | 1 | Bit returned by the chain under test |
| stimOut | output | 1 | Square-wave stimulus driven into the chain |
| evtPulse | output | 1 | One-cycle pulse when any counter is updated |
| irqFlag | output | 1 | Sticky functional-interrupt flag (reprogram request) |
| upsetCnt | output | 16 | Saturating count of single upsets |
| longCnt | output | 16 | Saturating count of long upsets |
| sefiCnt | output | 16 | Saturating count of functional interrupts |

## Verification
The bench aims at run-length boundaries:
- Runs of exactly 1, 2 and 49 samples. A design that is off by one moves the run into the wrong counter.
- A run of exactly 50 samples, checked after its last edge. A design that grades late or counts twice shows a missing or doubled interrupt.
- A long error stream after the flag is set. A design that keeps counting while locked is caught.
- Over 65,535 single upsets. A counter that wraps to zero is caught.
- A wave that arrives one edge late. It shows whether the latency of the expected bit is exact.

// File: rtl/chain_mon_pkg.sv
package chain_mon_pkg;
  // strobes from run control to the counting datapath
  typedef struct packed {
    logic upset;
    logic longUp;
    logic sefi;
  } evtStrobe_t;

  localparam int NUM_CLASSES = 3;
endpackage

// File: rtl/chain_mon_datapath.sv
module chain_mon_datapath
  import chain_mon_pkg::*;
#(
  parameter int LATENCY = 4,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chainIn,
  input  evtStrobe_t       strb,
  output logic             stimOut,
  output logic             mismatch,
  output logic             evtPulse,
  output logic [CNT_W-1:0] upsetCnt,
  output logic [CNT_W-1:0] longCnt,
  output logic [CNT_W-1:0] sefiCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic               stimReg;
  logic [LATENCY-1:0] delayLine;
  logic [NUM_CLASSES-1:0] incVec;
  logic [CNT_W-1:0]   cntArr [NUM_CLASSES];

  always_ff @(posedge clk) begin
    if (rst) stimReg <= 1'b0;
    else     stimReg <= ~stimReg;
  end

  // each stage resets to the level the wave had that many edges earlier
  genvar k;
  generate
    for (k = 0; k < LATENCY; k++) begin : g_dly
      always_ff @(posedge clk) begin
        if (rst) delayLine[k] <= 1'((k + 1) % 2);
        else if (k == 0) delayLine[k] <= stimReg;
        else delayLine[k] <= delayLine[(k == 0) ? 0 : k-1];
      end
    end
  endgenerate

  assign stimOut  = stimReg;
  assign mismatch = chainIn ^ delayLine[LATENCY-1];
  assign incVec   = {strb.sefi, strb.longUp, strb.upset};

  genvar c;
  generate
    for (c = 0; c < NUM_CLASSES; c++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst) cntArr[c] <= '0;
        else if (incVec[c] && cntArr[c] != CNT_MAX) cntArr[c] <= cntArr[c] + CNT_W'(1);
      end

      // R9
      no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cntArr[c] == CNT_MAX |=> cntArr[c] == CNT_MAX);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) evtPulse <= 1'b0;
    else     evtPulse <= |incVec;
  end

  assign upsetCnt = cntArr[0];
  assign longCnt  = cntArr[1];
  assign sefiCnt  = cntArr[2];

  // R4
  evt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    strb.upset && upsetCnt != CNT_MAX |=> evtPulse && upsetCnt == $past(upsetCnt) + CNT_W'(1));
endmodule

// File: rtl/chain_mon_control.sv
module chain_mon_control
  import chain_mon_pkg::*;
#(
  parameter int SEFI_RUN = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clrIrq,
  input  logic       mismatch,
  output evtStrobe_t strb,
  output logic       irqFlag
);
  localparam int RUN_W = $clog2(SEFI_RUN + 1);
  localparam logic [RUN_W-1:0] LAST_LEN = RUN_W'(SEFI_RUN - 1);

  logic [RUN_W-1:0] runLen;

  always_comb begin
    strb = '0;
    if (!clrIrq && !irqFlag) begin
      if (mismatch) begin
        if (runLen == LAST_LEN) strb.sefi = 1'b1;
      end else if (runLen == RUN_W'(1)) begin
        strb.upset = 1'b1;
      end else if (runLen > RUN_W'(1)) begin
        strb.longUp = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clrIrq) begin
      runLen  <= '0;
      irqFlag <= 1'b0;
    end else if (irqFlag) begin
      runLen  <= '0;
    end else if (mismatch) begin
      if (strb.sefi) begin
        runLen  <= '0;
        irqFlag <= 1'b1;
      end else begin
        runLen  <= runLen + RUN_W'(1);
      end
    end else begin
      runLen <= '0;
    end
  end

  // R5
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb));

  // R6
  sefi_flag_chk: assert property (@(posedge clk) disable iff (rst)
    strb.sefi |=> irqFlag);

  // R6
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    runLen < RUN_W'(SEFI_RUN));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clrIrq |=> !irqFlag && runLen == '0);
endmodule

// File: rtl/chain_err_monitor.sv
module chain_err_monitor
  import chain_mon_pkg::*;
#(
  parameter int LATENCY  = 4,
  parameter int SEFI_RUN = 50,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clrIrq,
  input  logic             chainIn,
  output logic             stimOut,
  output logic             evtPulse,
  output logic             irqFlag,
  output logic [CNT_W-1:0] upsetCnt,
  output logic [CNT_W-1:0] longCnt,
  output logic [CNT_W-1:0] sefiCnt
);
  evtStrobe_t strb;
  logic       mismatch;

  chain_mon_datapath #(.LATENCY(LATENCY), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .chainIn(chainIn), .strb(strb),
    .stimOut(stimOut), .mismatch(mismatch), .evtPulse(evtPulse),
    .upsetCnt(upsetCnt), .longCnt(longCnt), .sefiCnt(sefiCnt)
  );

  chain_mon_control #(.SEFI_RUN(SEFI_RUN)) u_ctl (
    .clk(clk), .rst(rst), .clrIrq(clrIrq), .mismatch(mismatch),
    .strb(strb), .irqFlag(irqFlag)
  );

  // R7
  locked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    irqFlag && !clrIrq |=> $stable(upsetCnt) && $stable(longCnt) && $stable(sefiCnt));

  // R2
  stim_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stimOut != $past(stimOut));
endmodule

// File: tb/test_chain_err_monitor.sv
module test_chain_err_monitor;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clrIrq = 1'b0;
  logic chainIn = 1'b0;
  logic stimOut, evtPulse, irqFlag;
  logic [15:0] upsetCnt, longCnt, sefiCnt;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int edgesTotal = 0;

  always #10 clk = ~clk;

  chain_err_monitor #(.LATENCY(LAT), .SEFI_RUN(50), .CNT_W(16)) i_chain_err_monitor (
    .clk(clk), .rst(rst), .clrIrq(clrIrq), .chainIn(chainIn),
    .stimOut(stimOut), .evtPulse(evtPulse), .irqFlag(irqFlag),
    .upsetCnt(upsetCnt), .longCnt(longCnt), .sefiCnt(sefiCnt)
  );

  // index of the next edge since reset release
  always @(posedge clk) begin
    edgesTotal <= edgesTotal + 1;
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one sample before the next edge; inj=1 corrupts it
  task automatic step(input bit inj, input int phase = 0);
    chainIn = 1'(((cyc + LAT + phase) & 1)) ^ inj;
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 stimOut", stimOut, 0);
    chk("R1 upsetCnt", upsetCnt, 0);
    chk("R1 longCnt", longCnt, 0);
    chk("R1 sefiCnt", sefiCnt, 0);
    chk("R1 irqFlag", irqFlag, 0);
    chk("R1 evtPulse", evtPulse, 0);
  endtask

  task automatic t_toggle();
    int mis = 0;
    for (int i = 0; i < 8; i++) begin
      if (stimOut !== 1'((cyc) & 1)) mis++;
      step(0);
    end
    chk("R2 stimulus toggles each edge", mis, 0);
  endtask

  task automatic t_clean();
    for (int i = 0; i < 200; i++) step(0);
    chk("R3 clean chain upsetCnt", upsetCnt, 0);
    chk("R3 clean chain longCnt", longCnt, 0);
    chk("R3 clean chain sefiCnt", sefiCnt, 0);
  endtask

  task automatic t_single();
    int u0 = upsetCnt;
    step(1); step(0);
    chk("R4 single upset count", upsetCnt, u0 + 1);
    chk("R4 event pulse high", evtPulse, 1);
    chk("R4 longCnt unchanged", longCnt, 0);
    step(0);
    chk("R4 event pulse one cycle", evtPulse, 0);
  endtask

  task automatic t_long(input int len);
    int l0 = longCnt;
    int u0 = upsetCnt;
    for (int i = 0; i < len; i++) step(1);
    step(0);
    chk($sformatf("R5 run %0d longCnt", len), longCnt, l0 + 1);
    chk($sformatf("R5 run %0d upsetCnt", len), upsetCnt, u0);
    chk($sformatf("R5 run %0d sefiCnt", len), sefiCnt, 0);
    chk("R5 irqFlag clear", irqFlag, 0);
  endtask

  task automatic t_sefi();
    int u0 = upsetCnt;
    int l0 = longCnt;
    for (int i = 0; i < 49; i++) step(1);
    chk("R6 no flag after 49", irqFlag, 0);
    step(1);
    chk("R6 flag after 50", irqFlag, 1);
    chk("R6 sefiCnt after 50", sefiCnt, 1);
    for (int i = 0; i < 60; i++) step(1);
    step(0); step(1); step(0);
    chk("R7 sefiCnt locked", sefiCnt, 1);
    chk("R7 upsetCnt locked", upsetCnt, u0);
    chk("R7 longCnt locked", longCnt, l0);
    chk("R7 flag sticky", irqFlag, 1);
    clrIrq = 1'b1; step(0); clrIrq = 1'b0;
    chk("R8 flag cleared", irqFlag, 0);
    step(1); step(0);
    chk("R8 counting resumes", upsetCnt, u0 + 1);
  endtask

  task automatic t_latency();
    int s0 = sefiCnt;
    for (int i = 0; i < 49; i++) step(0, 1);
    chk("R3 late wave no flag yet", irqFlag, 0);
    step(0, 1);
    chk("R3 late wave mismatches every sample", sefiCnt, s0 + 1);
    clrIrq = 1'b1; step(0); clrIrq = 1'b0;
  endtask

  task automatic t_midReset();
    doReset();
    chk("R10 upsetCnt cleared", upsetCnt, 0);
    chk("R10 longCnt cleared", longCnt, 0);
    chk("R10 sefiCnt cleared", sefiCnt, 0);
    chk("R10 flag cleared", irqFlag, 0);
    chk("R10 stimulus restarts", stimOut, 0);
    for (int i = 0; i < 20; i++) step(0);
    chk("R10 no false events after reset", upsetCnt + longCnt + sefiCnt, 0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 65540; i++) begin
      step(1); step(0);
    end
    chk("R9 upsetCnt saturates", upsetCnt, 65535);
    chk("R9 longCnt untouched", longCnt, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_toggle();
    t_clean();
    t_single();
    t_long(2);
    t_long(49);
    t_sefi();
    t_latency();
    t_midReset();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (edgesTotal >= 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<190000 edges", edgesTotal);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule